// File: doc/BRIEF.md
# Sprite Shifter and Pixel Priority Mux

This block is the last stage of a tile-based raster pipeline. It holds a small set of per-line sprite output slots. Each slot has an 8-bit horizontal delay counter, two 8-bit bit-plane shift registers, a 2-bit palette select and a priority flag. On every dot it merges the slots' pixels with a background pixel from another unit and produces one 5-bit palette index. It also raises a one-dot pulse when the sprite marked as the line's first table entry overlaps opaque background.

Some other unit writes the slots once per line, one slot per clock through a single load port. That unit also says how many slots are valid. After that it pulses the shift strobe once per dot. A slot waits, counting its delay down to zero, and only then starts to shift out its pattern, most significant bit first. The palette index and the hit pulse are combinational from the slot state and the current inputs.

Top module: `sprite_pixel_mux`

## Requirements
- R1: After synchronous reset every slot is cleared: counter, both planes, palette and priority are zero. With no slot loaded, the output index is the background index alone and `zero_hit` is low.
- R2: When `load_en` is high, slot `load_slot` takes the counter, both planes, the palette and the priority at the next clock edge. A load takes precedence over a shift on that slot in the same cycle: the loaded planes are stored unshifted.
- R3: On a shift strobe, an enabled and valid slot whose counter is non-zero decrements the counter by one and leaves its planes unchanged. While its counter is non-zero the slot is transparent.
- R4: On a shift strobe, an enabled and valid slot whose counter is zero shifts both planes left by one, bringing in a zero. Its pixel is {high plane bit 7, low plane bit 7}, so the high plane gives bit 1.
- R5: While `spr_en` is low, no slot shifts or counts and every sprite pixel is transparent. Slot state is kept for when `spr_en` returns high.
- R6: Only slots with an index below `active_cnt` take part. Other slots neither shift nor contribute a pixel.
- R7: Among the slots with a non-zero pixel, the lowest-numbered slot wins. A transparent lower slot does not hide a higher opaque one.
- R8: When `bg_en` is low, the background pixel is treated as zero whatever `bg_pat` holds.
- R9: Index encoding. If both pixels are zero, the index is 0. If only the sprite is opaque, the index is 16 + 4*palette + pixel. If only the background is opaque, the index is 4*`bg_pal` + `bg_pat`.
- R10: When both pixels are opaque, a winning slot with priority 0 gives the sprite index. A winning slot with priority 1 gives the background index.
- R11: `zero_hit` is high exactly when all of these hold: both pixels are opaque, `zero_here` is high, the winning slot equals `zero_slot`, `hit_armed` is high and `pix_x` is below 255. The priority flag has no effect on the hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_en | input | 1 | Sprite layer enable |
| bg_en | input | 1 | Background layer enable |
| shift_en | input | 1 | One-dot shift strobe |
| active_cnt | input | 4 | Number of valid slots (0..8) |
| load_en | input | 1 | Write one slot this cycle |
| load_slot | input | 3 | Slot to write |
| load_cnt | input | 8 | Horizontal delay counter value |
| load_lo | input | 8 | Low bit-plane pattern |
| load_hi | input | 8 | High bit-plane pattern |
| load_pal | input | 2 | Sprite palette select |
| load_prio | input | 1 | 1 = behind opaque background |
| zero_here | input | 1 | A valid slot holds the first table entry |
| zero_slot | input | 3 | Slot holding the first table entry |
| hit_armed | input | 1 | Hit detection armed for this line |
| pix_x | input | 9 | Current horizontal position |
| bg_pat | input | 2 | Background pixel |
| bg_pal | input | 2 | Background palette select |
| pal_idx | output | 5 | Resulting palette index |
| zero_hit | output | 1 | First-entry overlap pulse |

## Verification
A slot write and a shift strobe can fall in the same cycle, and so can a hit and a background-priority win. The bench loads a slot while the strobe is held high and uses an early-zero pattern, so that a shifted store and an unshifted one give different pixels. It then strobes once more and checks that the pixel appears only then. For the second pair it gives the first-entry slot priority 1 over opaque background. It then expects the background index together with a high `zero_hit`.

// File: rtl/spx_pkg.sv
package spx_pkg;
    localparam int CNT_W   = 8;
    localparam int PAT_W   = 8;
    localparam int PAL_W   = 2;
    localparam int PIX_W   = 2;
    localparam int X_W     = 9;
    localparam int IDX_W   = 1 + PAL_W + PIX_W;
    localparam int X_LIMIT = 255;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PAT_W-1:0] lo;
        logic [PAT_W-1:0] hi;
        logic [PAL_W-1:0] pal;
        logic             prio;
    } slot_t;

    function automatic logic [IDX_W-1:0] make_idx(input logic spr,
                                                 input logic [PAL_W-1:0] pal,
                                                 input logic [PIX_W-1:0] pix);
        return {spr, pal, pix};
    endfunction
endpackage

// File: rtl/spx_slot.sv
module spx_slot
    import spx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  slot_t            ld_val,
    input  logic             step,
    input  logic             vis,
    output slot_t            st,
    output logic [PIX_W-1:0] pix
);
    slot_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (ld) begin
            cur <= ld_val;
        end else if (step) begin
            if (cur.cnt != '0) begin
                cur.cnt <= cur.cnt - 1'b1;
            end else begin
                cur.lo <= {cur.lo[PAT_W-2:0], 1'b0};
                cur.hi <= {cur.hi[PAT_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        pix = '0;
        if (vis && cur.cnt == '0) pix = {cur.hi[PAT_W-1], cur.lo[PAT_W-1]};
    end

    assign st = cur;

    a_r2_load_takes: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cur == $past(ld_val)));
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && cur.cnt != '0) |=> (cur.cnt == $past(cur.cnt) - 1'b1) && $stable(cur.lo));
    a_r4_plane_shift: assert property (@(posedge clk) disable iff (rst)
        (step && !ld && cur.cnt == '0) |=> (cur.lo == {$past(cur.lo[PAT_W-2:0]), 1'b0}));
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!step && !ld) |=> $stable(cur));
endmodule

// File: rtl/spx_select.sv
module spx_select
    import spx_pkg::*;
#(
    parameter int N_SLOTS = 8,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0][PIX_W-1:0] pix_v,
    input  slot_t [N_SLOTS-1:0]           st_v,
    output logic                          found,
    output logic [SW-1:0]                 win,
    output logic [PIX_W-1:0]              win_pix,
    output logic [PAL_W-1:0]              win_pal,
    output logic                          win_prio
);
    always_comb begin
        found    = 1'b0;
        win      = '0;
        win_pix  = '0;
        win_pal  = '0;
        win_prio = 1'b0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (pix_v[i] != '0) begin
                found    = 1'b1;
                win      = SW'(i);
                win_pix  = pix_v[i];
                win_pal  = st_v[i].pal;
                win_prio = st_v[i].prio;
            end
        end
    end
endmodule

// File: rtl/spx_compose.sv
module spx_compose
    import spx_pkg::*;
#(
    parameter int SW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bg_en,
    input  logic [PIX_W-1:0] bg_pat,
    input  logic [PAL_W-1:0] bg_pal,
    input  logic             found,
    input  logic [SW-1:0]    win,
    input  logic [PIX_W-1:0] win_pix,
    input  logic [PAL_W-1:0] win_pal,
    input  logic             win_prio,
    input  logic             zero_here,
    input  logic [SW-1:0]    zero_slot,
    input  logic             hit_armed,
    input  logic [X_W-1:0]   pix_x,
    output logic [IDX_W-1:0] pal_idx,
    output logic             zero_hit
);
    logic [PIX_W-1:0] bg_eff;
    logic             bg_op;

    assign bg_eff = bg_en ? bg_pat : '0;
    assign bg_op  = (bg_eff != '0);

    always_comb begin
        if (found && (!bg_op || !win_prio)) pal_idx = make_idx(1'b1, win_pal, win_pix);
        else if (bg_op)                     pal_idx = make_idx(1'b0, bg_pal, bg_eff);
        else                                pal_idx = '0;
    end

    assign zero_hit = found && bg_op && zero_here && hit_armed &&
                      (win == zero_slot) && (pix_x < X_W'(X_LIMIT));

    a_r11_hit_needs_bg: assert property (@(posedge clk) disable iff (rst)
        zero_hit |-> (bg_en && bg_pat != '0 && hit_armed && pix_x < X_W'(X_LIMIT)));
    a_r9_blank_zero: assert property (@(posedge clk) disable iff (rst)
        (!found && (!bg_en || bg_pat == '0)) |-> (pal_idx == '0));
    a_r8_bg_off: assert property (@(posedge clk) disable iff (rst)
        (!bg_en && !found) |-> (pal_idx == '0 && !zero_hit));
endmodule

// File: rtl/sprite_pixel_mux.sv
module sprite_pixel_mux
    import spx_pkg::*;
#(
    parameter int N_SLOTS = 8,
    localparam int SW = $clog2(N_SLOTS),
    localparam int AW = $clog2(N_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spr_en,
    input  logic             bg_en,
    input  logic             shift_en,
    input  logic [AW-1:0]    active_cnt,
    input  logic             load_en,
    input  logic [SW-1:0]    load_slot,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic [PAT_W-1:0] load_lo,
    input  logic [PAT_W-1:0] load_hi,
    input  logic [PAL_W-1:0] load_pal,
    input  logic             load_prio,
    input  logic             zero_here,
    input  logic [SW-1:0]    zero_slot,
    input  logic             hit_armed,
    input  logic [X_W-1:0]   pix_x,
    input  logic [PIX_W-1:0] bg_pat,
    input  logic [PAL_W-1:0] bg_pal,
    output logic [IDX_W-1:0] pal_idx,
    output logic             zero_hit
);
    slot_t                         ld_val;
    slot_t [N_SLOTS-1:0]           st_v;
    logic  [N_SLOTS-1:0][PIX_W-1:0] pix_v;
    logic                          found;
    logic  [SW-1:0]                win;
    logic  [PIX_W-1:0]             win_pix;
    logic  [PAL_W-1:0]             win_pal;
    logic                          win_prio;

    assign ld_val = '{cnt: load_cnt, lo: load_lo, hi: load_hi, pal: load_pal, prio: load_prio};

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic valid;
        assign valid = (AW'(g) < active_cnt) && spr_en;
        spx_slot u_slot (
            .clk    (clk),
            .rst    (rst),
            .ld     (load_en && load_slot == SW'(g)),
            .ld_val (ld_val),
            .step   (shift_en && valid),
            .vis    (valid),
            .st     (st_v[g]),
            .pix    (pix_v[g])
        );
    end

    spx_select #(.N_SLOTS(N_SLOTS)) u_sel (
        .pix_v    (pix_v),
        .st_v     (st_v),
        .found    (found),
        .win      (win),
        .win_pix  (win_pix),
        .win_pal  (win_pal),
        .win_prio (win_prio)
    );

    spx_compose #(.SW(SW)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .bg_en     (bg_en),
        .bg_pat    (bg_pat),
        .bg_pal    (bg_pal),
        .found     (found),
        .win       (win),
        .win_pix   (win_pix),
        .win_pal   (win_pal),
        .win_prio  (win_prio),
        .zero_here (zero_here),
        .zero_slot (zero_slot),
        .hit_armed (hit_armed),
        .pix_x     (pix_x),
        .pal_idx   (pal_idx),
        .zero_hit  (zero_hit)
    );

    a_r5_dark_when_off: assert property (@(posedge clk) disable iff (rst)
        !spr_en |-> (pal_idx[IDX_W-1] == 1'b0 && !zero_hit));
    a_r6_none_active: assert property (@(posedge clk) disable iff (rst)
        (active_cnt == '0) |-> (!found && !zero_hit));
endmodule

// File: tb/sim_sprite_pixel_mux.sv
module sim_sprite_pixel_mux;
    logic       clk = 0;
    logic       rst = 1;
    logic       spr_en = 0, bg_en = 0, shift_en = 0, load_en = 0;
    logic [3:0] active_cnt = 0;
    logic [2:0] load_slot = 0, zero_slot = 0;
    logic [7:0] load_cnt = 0, load_lo = 0, load_hi = 0;
    logic [1:0] load_pal = 0, bg_pat = 0, bg_pal = 0;
    logic       load_prio = 0, zero_here = 0, hit_armed = 0;
    logic [8:0] pix_x = 0;
    logic [4:0] pal_idx;
    logic       zero_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sprite_pixel_mux u0 (
        .clk(clk), .rst(rst), .spr_en(spr_en), .bg_en(bg_en), .shift_en(shift_en),
        .active_cnt(active_cnt), .load_en(load_en), .load_slot(load_slot),
        .load_cnt(load_cnt), .load_lo(load_lo), .load_hi(load_hi),
        .load_pal(load_pal), .load_prio(load_prio), .zero_here(zero_here),
        .zero_slot(zero_slot), .hit_armed(hit_armed), .pix_x(pix_x),
        .bg_pat(bg_pat), .bg_pal(bg_pal), .pal_idx(pal_idx), .zero_hit(zero_hit)
    );

    task automatic chk_idx(input string req, input logic [4:0] exp);
        #1;
        checks++;
        if (pal_idx !== exp) begin
            errors++;
            $display("FAIL %s pal_idx actual=%0d expected=%0d", req, pal_idx, exp);
        end
    endtask

    task automatic chk_hit(input string req, input logic exp);
        #1;
        checks++;
        if (zero_hit !== exp) begin
            errors++;
            $display("FAIL %s zero_hit actual=%0b expected=%0b", req, zero_hit, exp);
        end
    endtask

    task automatic load(input int s, input int c, input int lo, input int hi,
                        input int pal, input int prio, input bit with_shift);
        @(negedge clk);
        load_slot = 3'(s); load_cnt = 8'(c); load_lo = 8'(lo); load_hi = 8'(hi);
        load_pal = 2'(pal); load_prio = prio[0]; load_en = 1; shift_en = with_shift;
        @(negedge clk);
        load_en = 0; shift_en = 0;
    endtask

    task automatic shift(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); shift_en = 1;
            @(negedge clk); shift_en = 0;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        bg_en = 1; spr_en = 1; active_cnt = 8; bg_pat = 2; bg_pal = 1;
        chk_idx("R1 reset bg only", 5'd6);
        chk_hit("R1 reset no hit", 1'b0);
        bg_pat = 0;
    endtask

    task automatic t_count_shift;
        load(0, 2, 8'h80, 8'h00, 3, 0, 0);
        chk_idx("R3 delayed slot transparent", 5'd0);
        shift(1);
        chk_idx("R3 counter 1 still transparent", 5'd0);
        shift(1);
        chk_idx("R4 counter zero pixel shows", 5'd29);
        shift(1);
        chk_idx("R4 plane shifted out", 5'd0);
    endtask

    task automatic t_disable;
        load(0, 0, 8'h00, 8'h80, 0, 0, 0);
        spr_en = 0;
        chk_idx("R5 sprite layer off transparent", 5'd0);
        shift(3);
        spr_en = 1;
        chk_idx("R5 state held while off", 5'd18);
        active_cnt = 0;
        chk_idx("R6 no active slot", 5'd0);
        shift(2);
        active_cnt = 8;
        chk_idx("R6 inactive slot did not shift", 5'd18);
    endtask

    task automatic t_order;
        load(1, 0, 8'h80, 8'h00, 1, 0, 0);
        chk_idx("R7 lowest slot wins", 5'd18);
        load(0, 0, 0, 0, 0, 0, 0);
        chk_idx("R7 transparent lower slot skipped", 5'd21);
    endtask

    task automatic t_priority;
        load(1, 0, 8'h80, 8'h00, 1, 1, 0);
        bg_pat = 3; bg_pal = 2;
        chk_idx("R10 background in front", 5'd11);
        bg_en = 0;
        chk_idx("R8 background disabled", 5'd21);
        bg_en = 1; spr_en = 0;
        chk_idx("R9 background only index", 5'd11);
        spr_en = 1;
        load(1, 0, 8'h80, 8'h00, 1, 0, 0);
        chk_idx("R10 sprite in front", 5'd21);
    endtask

    task automatic t_hit;
        load(1, 0, 8'h80, 8'h00, 1, 1, 0);
        zero_here = 1; zero_slot = 1; hit_armed = 1; pix_x = 10;
        chk_hit("R11 hit with priority 1", 1'b1);
        chk_idx("R10 bg wins during hit", 5'd11);
        pix_x = 255;
        chk_hit("R11 no hit at x 255", 1'b0);
        pix_x = 254;
        chk_hit("R11 hit at x 254", 1'b1);
        hit_armed = 0;
        chk_hit("R11 not armed", 1'b0);
        hit_armed = 1; zero_slot = 0;
        chk_hit("R11 other slot", 1'b0);
        zero_slot = 1; zero_here = 0;
        chk_hit("R11 first entry absent", 1'b0);
        zero_here = 1; bg_pat = 0;
        chk_hit("R11 transparent background", 1'b0);
        zero_here = 0; hit_armed = 0;
    endtask

    task automatic t_load_vs_shift;
        load(1, 0, 0, 0, 0, 0, 0);
        load(2, 0, 8'h40, 8'h00, 0, 0, 1);
        chk_idx("R2 load beats shift", 5'd0);
        active_cnt = 2;
        shift(1);
        chk_idx("R6 slot 2 outside count", 5'd0);
        active_cnt = 8;
        chk_idx("R6 slot 2 unshifted", 5'd0);
        shift(1);
        chk_idx("R2 pixel after one shift", 5'd17);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_count_shift();
        t_disable();
        t_order();
        t_priority();
        t_hit();
        t_load_vs_shift();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule